// File: doc/BRIEF.md
# Machine-Cycle Timer / Event Counter

This block is a 16-bit up-counter for a microcontroller-class core. It runs from the system clock. A local phase counter divides that clock into machine cycles of twelve clocks each. The count register advances in one of two ways:

- In timer function it advances once per machine cycle.
- In counter function it advances once per falling edge seen on an external event pin. The pin is synchronised, then sampled once per machine cycle at a fixed late phase, and an edge is a high sample followed by a low sample.

An increment found during one machine cycle is applied at the boundary that ends that cycle. The new value therefore appears in the following machine cycle.

Software controls the block through a few inputs. A run enable starts and stops counting. A select input picks the count source. A parallel write port loads the count, and the count is always readable on an output bus. When the count wraps from all ones to zero, an overflow flag is raised. The interrupt logic clears that flag with a one-clock acknowledge when it takes the interrupt. A one-clock machine-cycle strobe is also brought out so that neighbouring logic can share the same cycle timing.

Top module: `mctc_timer`

## Requirements
- R1: While rst_n is low at a clock edge, the count goes to 0x0000 and ovf_flag goes to 0.
- R2: mc_tick is high for exactly one clock in every 12 clocks. That clock is the last clock of a machine cycle.
- R3: With count_sel = 0 (timer) and run_en = 1, the count increases by one on every clock where mc_tick is high.
- R4: With count_sel = 1 (counter) and run_en = 1, the count increases by one for each falling edge on ext_pin. An edge is a sample read 1 followed by a sample read 0 in the next machine cycle, with ext_pin held for at least one machine cycle per level. Machine cycles without such an edge leave the count unchanged.
- R5: In counter function, a falling edge detected in one machine cycle changes the count at the mc_tick that ends that same cycle. The count is unchanged at the last clock before that tick, and it is one higher right after it.
- R6: With run_en = 0 and no write, the count holds its value. This applies in both functions, and edges on ext_pin are ignored.
- R7: An increment from 0xFFFF gives 0x0000 and sets ovf_flag in the same clock.
- R8: A one-clock int_ack clears ovf_flag. If an overflow occurs in the same clock, the flag stays set.
- R9: wr_en = 1 loads wr_data into the count on the next edge. The write takes priority over a same-clock increment, and no overflow is raised in that clock.
- R10: Between edges without a write, the count either holds or increases by exactly one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| run_en | input | 1 | Run control: 1 counts, 0 holds |
| count_sel | input | 1 | Count source: 0 machine cycles, 1 external falling edges |
| ext_pin | input | 1 | External event input, asynchronous |
| wr_en | input | 1 | Software load strobe for the count |
| wr_data | input | 16 | Value loaded when wr_en is high |
| int_ack | input | 1 | Interrupt acknowledge, clears the overflow flag |
| count_val | output | 16 | Current count |
| ovf_flag | output | 1 | Overflow flag, set on wrap to zero |
| mc_tick | output | 1 | One-clock strobe marking the end of each machine cycle |

## Verification
The properties assume that wr_en, run_en, count_sel and int_ack are synchronous to clk. They also assume ext_pin holds each level for at least one machine cycle, since pulses shorter than the sampling interval can be missed. The bench drives every control input at the falling clock edge. It holds each ext_pin level for 36 clocks, which is three machine cycles, so every edge it makes is seen exactly once. Writes and acknowledges that must collide with an increment are placed on the clock where mc_tick is observed high.

// File: rtl/mctc_pkg.sv
// Package: shared types and constants for the machine-cycle timer/counter.
// Assumes: nothing; pure declarations.
package mctc_pkg;

    // Source of increments for the count register
    typedef enum logic {
        SRC_TIMER   = 1'b0,
        SRC_COUNTER = 1'b1
    } count_src_e;

    // Default geometry
    localparam int unsigned DEF_WIDTH        = 16;
    localparam int unsigned DEF_CLKS_PER_MC  = 12;
    localparam int unsigned DEF_SAMPLE_PHASE = 9;

endpackage

// File: rtl/mctc_cycle_gen.sv
// Module: machine-cycle phase generator.
// Divides clk into machine cycles of CLKS_PER_MC clocks. It raises mc_tick on
// the last phase and sample_stb on SAMPLE_PHASE.
// Assumes: CLKS_PER_MC >= 3 and SAMPLE_PHASE < CLKS_PER_MC - 1, so the sample
// always lands before the end-of-cycle tick.
module mctc_cycle_gen #(
    parameter int unsigned CLKS_PER_MC  = 12,
    parameter int unsigned SAMPLE_PHASE = 9
) (
    input  logic clk,
    input  logic rst_n,
    output logic mc_tick,
    output logic sample_stb
);
    localparam int unsigned PW = (CLKS_PER_MC > 1) ? $clog2(CLKS_PER_MC) : 1;
    localparam logic [PW-1:0] LAST_PH = PW'(CLKS_PER_MC - 1);
    localparam logic [PW-1:0] SMP_PH  = PW'(SAMPLE_PHASE);

    logic [PW-1:0] phase_q;

    // Phase counter: steps 0..CLKS_PER_MC-1 and wraps
    always_ff @(posedge clk) begin
        if (!rst_n)                phase_q <= '0;
        else if (phase_q == LAST_PH) phase_q <= '0;
        else                       phase_q <= phase_q + 1'b1;
    end

    // Strobe decode from the phase
    always_comb begin
        mc_tick    = (phase_q == LAST_PH);
        sample_stb = (phase_q == SMP_PH);
    end
endmodule

// File: rtl/mctc_fall_detect.sv
// Module: external falling-edge detector.
// Synchronises ext_pin through two flops and samples it once per machine cycle
// on sample_stb. It sets edge_evt when the new sample is 0 and the previous one
// was 1. edge_evt stays high until the mc_tick that closes the machine cycle.
// Assumes: sample_stb and mc_tick never coincide.
module mctc_fall_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_pin,
    input  logic sample_stb,
    input  logic mc_tick,
    output logic edge_evt
);
    logic [1:0] sync_q;
    logic       smp_q;

    // Two-flop synchroniser for the asynchronous pin
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 2'b00;
        else        sync_q <= {sync_q[0], ext_pin};
    end

    // Once-per-machine-cycle sample of the synchronised level
    always_ff @(posedge clk) begin
        if (!rst_n)          smp_q <= 1'b0;
        else if (sample_stb) smp_q <= sync_q[1];
    end

    // Edge event: set on a 1-then-0 sample pair, cleared at cycle end
    always_ff @(posedge clk) begin
        if (!rst_n)                                  edge_evt <= 1'b0;
        else if (mc_tick)                            edge_evt <= 1'b0;
        else if (sample_stb && smp_q && !sync_q[1])  edge_evt <= 1'b1;
    end
endmodule

// File: rtl/mctc_count_core.sv
// Module: count register with load and overflow flag.
// A write wins over an increment. An increment from all ones wraps to zero
// and sets ovf. int_ack clears ovf unless an overflow happens in the same clock.
// Assumes: inc is a single-clock request.
module mctc_count_core #(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             inc,
    input  logic             int_ack,
    output logic [WIDTH-1:0] count,
    output logic             ovf
);
    localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

    logic [WIDTH-1:0] count_d;
    logic             wrap;

    // Next count: write, then increment, else hold
    always_comb begin
        wrap    = 1'b0;
        count_d = count;
        if (wr_en) begin
            count_d = wr_data;
        end else if (inc) begin
            count_d = count + 1'b1;
            wrap    = (count == ALL_ONES);
        end
    end

    // Count register
    always_ff @(posedge clk) begin
        if (!rst_n) count <= '0;
        else        count <= count_d;
    end

    // Overflow flag: set on wrap, clear on acknowledge, set wins
    always_ff @(posedge clk) begin
        if (!rst_n)       ovf <= 1'b0;
        else if (wrap)    ovf <= 1'b1;
        else if (int_ack) ovf <= 1'b0;
    end
endmodule

// File: rtl/mctc_timer.sv
// Module: top of the machine-cycle timer/event counter.
// Combines the phase generator, the edge detector and the count core. It
// counts machine cycles or external falling edges, chosen by count_sel, and
// only while run_en is high.
// Assumes: all control inputs except ext_pin are synchronous to clk.
module mctc_timer
    import mctc_pkg::*;
#(
    parameter int unsigned WIDTH        = DEF_WIDTH,
    parameter int unsigned CLKS_PER_MC  = DEF_CLKS_PER_MC,
    parameter int unsigned SAMPLE_PHASE = DEF_SAMPLE_PHASE
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             count_sel,
    input  logic             ext_pin,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             int_ack,
    output logic [WIDTH-1:0] count_val,
    output logic             ovf_flag,
    output logic             mc_tick
);
    count_src_e src;
    logic       sample_stb;
    logic       edge_evt;
    logic       inc;

    mctc_cycle_gen #(
        .CLKS_PER_MC  (CLKS_PER_MC),
        .SAMPLE_PHASE (SAMPLE_PHASE)
    ) u_cycle (
        .clk        (clk),
        .rst_n      (rst_n),
        .mc_tick    (mc_tick),
        .sample_stb (sample_stb)
    );

    mctc_fall_detect u_fall (
        .clk        (clk),
        .rst_n      (rst_n),
        .ext_pin    (ext_pin),
        .sample_stb (sample_stb),
        .mc_tick    (mc_tick),
        .edge_evt   (edge_evt)
    );

    // Increment request: one per machine cycle, qualified by source and run
    always_comb begin
        src = count_src_e'(count_sel);
        inc = 1'b0;
        if (run_en && mc_tick) begin
            inc = (src == SRC_TIMER) ? 1'b1 : edge_evt;
        end
    end

    mctc_count_core #(
        .WIDTH (WIDTH)
    ) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .inc     (inc),
        .int_ack (int_ack),
        .count   (count_val),
        .ovf     (ovf_flag)
    );
endmodule

// File: rtl/mctc_timer_chk.sv
// Module: property checker for mctc_timer, attached by bind.
// Assumes: it sees only the top-level ports.
module mctc_timer_chk #(
    parameter int unsigned WIDTH = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run_en,
    input logic             count_sel,
    input logic             ext_pin,
    input logic             wr_en,
    input logic [WIDTH-1:0] wr_data,
    input logic             int_ack,
    input logic [WIDTH-1:0] count_val,
    input logic             ovf_flag,
    input logic             mc_tick
);
    localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

    // R2: the machine-cycle strobe is never high on two clocks in a row
    a_r2_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
        mc_tick |=> !mc_tick);

    // R6: stopped and not written means the count holds
    a_r6_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !wr_en) |=> $stable(count_val));

    // R3: a running timer advances at the tick
    a_r3_timer_step: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !count_sel && mc_tick && !wr_en) |=>
            (count_val == $past(count_val) + 1'b1));

    // R7: the flag rises only on a wrap to zero
    a_r7_flag_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> ($past(count_val) == ALL_ONES && count_val == '0));

    // R8: an acknowledge without a same-clock overflow clears the flag
    a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (int_ack && !(run_en && mc_tick && count_val == ALL_ONES && !wr_en))
            |=> !ovf_flag);

    // R9: a write always loads the presented value
    a_r9_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (count_val == $past(wr_data)));

    // R10: without a write the count holds or steps by one
    a_r10_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (count_val == $past(count_val) ||
                    count_val == $past(count_val) + 1'b1));

    // R5: the count only moves at a tick or on a write
    a_r5_moves_at_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !mc_tick) |=> $stable(count_val));
endmodule

bind mctc_timer mctc_timer_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/mctc_timer_bench.sv
module mctc_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        run_en, count_sel, ext_pin, wr_en, int_ack;
    logic [15:0] wr_data;
    logic [15:0] count_val;
    logic        ovf_flag, mc_tick;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    mctc_timer u_mctc_timer (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .count_sel(count_sel),
        .ext_pin(ext_pin), .wr_en(wr_en), .wr_data(wr_data), .int_ack(int_ack),
        .count_val(count_val), .ovf_flag(ovf_flag), .mc_tick(mc_tick)
    );

    // Vector table: source, load, units (ticks or edges), expected count, flag
    localparam int NV = 9;
    localparam logic        V_SEL  [NV] = '{0, 0, 0, 0, 0, 1, 1, 1, 0};
    localparam logic [15:0] V_LOAD [NV] = '{16'h0000, 16'h1234, 16'hFFFE, 16'hFFFE,
                                            16'hFFFF, 16'h0000, 16'hFFFF, 16'h00FF, 16'hABCD};
    localparam int          V_N    [NV] = '{5, 16, 1, 3, 1, 3, 2, 1, 0};
    localparam logic [15:0] V_EXP  [NV] = '{16'h0005, 16'h1244, 16'hFFFF, 16'h0001,
                                            16'h0000, 16'h0003, 16'h0001, 16'h0100, 16'hABCD};
    localparam logic        V_FLG  [NV] = '{0, 0, 0, 1, 1, 0, 1, 0, 0};

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    task automatic load(input logic [15:0] v);
        @(negedge clk); wr_en = 1'b1; wr_data = v;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic ack();
        @(negedge clk); int_ack = 1'b1;
        @(negedge clk); int_ack = 1'b0;
    endtask

    task automatic to_tick();
        @(negedge clk);
        while (!mc_tick) @(negedge clk);
    endtask

    // Run in timer mode for n ticks; returns at the negedge after the last one
    task automatic run_ticks(input int n);
        int k = 0;
        @(negedge clk);
        run_en = 1'b1;
        while (k < n) begin
            if (mc_tick) k++;
            @(negedge clk);
        end
        run_en = 1'b0;
    endtask

    // Produce n falling edges on ext_pin, each level held 36 clocks
    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            ext_pin = 1'b0; repeat (36) @(negedge clk);
            ext_pin = 1'b1; repeat (36) @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual running expected done");
            report();
        end
    end

    initial begin
        int gap;
        rst_n = 1'b0; run_en = 1'b0; count_sel = 1'b0; ext_pin = 1'b0;
        wr_en = 1'b0; int_ack = 1'b0; wr_data = '0;
        repeat (4) @(negedge clk);
        // R1: reset state
        chk("R1 count", count_val, 16'h0000);
        chk("R1 flag", {15'd0, ovf_flag}, 16'd0);
        rst_n = 1'b1;

        // R2: twelve clocks between ticks
        to_tick();
        gap = 0;
        do begin @(negedge clk); gap++; end while (!mc_tick);
        chk("R2 tick period", 16'(gap), 16'd12);

        // Vector walk: R3 timer, R4 counter, R7 wrap
        for (int v = 0; v < NV; v++) begin
            count_sel = V_SEL[v];
            ext_pin   = 1'b1;
            repeat (36) @(negedge clk);
            load(V_LOAD[v]);
            ack();
            if (!V_SEL[v]) begin
                run_ticks(V_N[v]);
            end else begin
                run_en = 1'b1;
                pulses(V_N[v]);
                repeat (24) @(negedge clk);
                run_en = 1'b0;
            end
            @(negedge clk);
            chk(V_SEL[v] ? "R4 count" : "R3 count", count_val, V_EXP[v]);
            chk("R7 flag", {15'd0, ovf_flag}, {15'd0, V_FLG[v]});
        end

        // R6: stopped timer holds
        count_sel = 1'b0;
        load(16'h55AA);
        repeat (50) @(negedge clk);
        chk("R6 timer hold", count_val, 16'h55AA);

        // R6: stopped counter ignores edges
        count_sel = 1'b1;
        pulses(2);
        chk("R6 counter hold", count_val, 16'h55AA);

        // R5: edge dropped at a tick is applied at the next tick
        load(16'h0000);
        run_en = 1'b1;
        to_tick();
        ext_pin = 1'b0;
        to_tick();
        chk("R5 before tick", count_val, 16'h0000);
        @(negedge clk);
        chk("R5 after tick", count_val, 16'h0001);
        run_en = 1'b0; ext_pin = 1'b1;
        repeat (36) @(negedge clk);

        // R9: write beats same-clock increment
        count_sel = 1'b0;
        load(16'h0010);
        run_en = 1'b1;
        to_tick();
        wr_en = 1'b1; wr_data = 16'h0100;
        @(negedge clk);
        wr_en = 1'b0; run_en = 1'b0;
        chk("R9 write wins", count_val, 16'h0100);

        // R9: write over a would-be wrap raises no flag
        ack();
        load(16'hFFFF);
        run_en = 1'b1;
        to_tick();
        wr_en = 1'b1; wr_data = 16'h0007;
        @(negedge clk);
        wr_en = 1'b0; run_en = 1'b0;
        chk("R9 no wrap count", count_val, 16'h0007);
        chk("R9 no flag", {15'd0, ovf_flag}, 16'd0);

        // R8: overflow beats a same-clock acknowledge, then ack clears
        load(16'hFFFF);
        run_en = 1'b1;
        to_tick();
        int_ack = 1'b1;
        @(negedge clk);
        int_ack = 1'b0; run_en = 1'b0;
        chk("R8 set wins", {15'd0, ovf_flag}, 16'd1);
        chk("R7 wrap value", count_val, 16'h0000);
        ack();
        chk("R8 ack clears", {15'd0, ovf_flag}, 16'd0);

        // R1: reset mid-run clears state
        load(16'h4321);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        chk("R1 re-reset", count_val, 16'h0000);
        rst_n = 1'b1;

        done = 1'b1;
        report();
    end
endmodule